// File: doc/BRIEF.md
# Data Translation Buffer Fill and Invalidate Controller

This block holds a small, fully associative set of virtual-to-physical page translations and maintains it through privileged register writes on one shared write port. A fill takes two steps. Software first writes a page-table-entry value into a staging register, which by itself changes nothing in the buffer. A later tag write then commits a new entry. That entry combines the tag's virtual page number, the staged fields, and the address-space number held in a separate register. Three control writes remove entries: one clears the whole buffer, one clears only the entries private to a process, and one clears a single page under the current address space.

A read port returns the staged entry repacked into its architectural bit layout. A combinational lookup port translates a virtual page number in the same cycle. A parameter selects an instruction-side variant, in which every fill loads zero write enables.

Top module: `tlb_fill_ctrl`

## Requirements
- R1: After reset, every entry is invalid, so every lookup misses. The staged entry and the address-space number are zero, `rd_pte` reads 0 and `gh_err` is low.
- R2: A write with `wr_sel`=0 stores `wr_data` as the staged entry and inserts nothing. It uses these fields: physical page number at bits 58:32, read enables at 11:8, write enables at 15:12, fault-on-read at bit 1, fault-on-write at bit 2, global (address-space-match) at bit 4, and granularity hint at bits 6:5. A write with `wr_sel`=1 loads the address-space number from bits 63:57.
- R3: A write with `wr_sel`=2 is a tag write. When the staged hint is zero, it inserts an entry from the next cycle on. The entry holds the virtual page number in `wr_data[PAGE_BITS+VPN_W-1:PAGE_BITS]`, the staged fields, and the current address-space number.
- R4: A tag write made while the staged hint is nonzero inserts nothing and leaves the replacement pointer where it was. It raises `gh_err` for the single following cycle.
- R5: `rd_pte` places the staged fields at the positions listed in R2 and ORs in the current address-space number at bits 63:57. The two fields share bits 58:57. The hint is not returned.
- R6: A write with `wr_sel`=3 invalidates every entry.
- R7: A write with `wr_sel`=4 invalidates every entry whose global bit is clear. Global entries survive.
- R8: A write with `wr_sel`=5 invalidates each valid entry whose page number equals the address's page field, provided that the entry is either global or carries the current address-space number.
- R9: A lookup hits when a valid entry has the same page number and is either global or carries the current address-space number. In that same cycle it returns the page number, the enables and the fault bits. When several entries match, the lowest-numbered one wins. A miss drives all lookup data to zero.
- R10: Entries are replaced round-robin among `ENTRIES` slots (8 by default), using a pointer that advances on each accepted insert. Insert number ENTRIES+1 overwrites the first.
- R11: With `IS_INSN`=1, every inserted entry holds zero write enables.
- R12: Writes with `wr_sel` 6 or 7 change neither the buffer, the staged entry nor the address-space number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 64 | Write value |
| rd_pte | output | 64 | Staged entry in architectural layout |
| gh_err | output | 1 | Tag write rejected for a nonzero hint |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_hit | output | 1 | Lookup found a translation |
| lk_ppn | output | 27 | Translated physical page number |
| lk_rd_en | output | 4 | Read enables of the hit entry |
| lk_wr_en | output | 4 | Write enables of the hit entry |
| lk_rd_fault | output | 1 | Fault-on-read of the hit entry |
| lk_wr_fault | output | 1 | Fault-on-write of the hit entry |

## Verification
Every register write takes effect at the clock edge that samples it. The staged read-back, the address-space number and the buffer contents therefore change one edge after the write. `gh_err` is high for exactly the cycle that follows the rejected tag write. Lookups add no register, so a result is due as soon as `lk_vpn` settles. The bench drives each write for one cycle between falling edges and checks `gh_err` and `rd_pte` at the next falling edge. While the clock is low, it steps `lk_vpn` through several page numbers and compares each lookup after a short settle delay, well before the next rising edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int PPN_W   = 27;
  localparam int PERM_W  = 4;
  localparam int ASN_W   = 7;
  localparam int GH_W    = 2;

  localparam int PPN_LSB = 32;
  localparam int RE_LSB  = 8;
  localparam int WE_LSB  = 12;
  localparam int FOR_BIT = 1;
  localparam int FOW_BIT = 2;
  localparam int GLB_BIT = 4;
  localparam int GH_LSB  = 5;
  localparam int ASN_LSB = 57;

  typedef enum logic [2:0] {
    SEL_PTE      = 3'd0,
    SEL_ASN      = 3'd1,
    SEL_TAG      = 3'd2,
    SEL_INV_ALL  = 3'd3,
    SEL_INV_PROC = 3'd4,
    SEL_INV_ONE  = 3'd5
  } wsel_e;

  typedef struct packed {
    logic [PPN_W-1:0]  ppn;
    logic [PERM_W-1:0] re;
    logic [PERM_W-1:0] we;
    logic              fo_rd;
    logic              fo_wr;
    logic              glb;
    logic [GH_W-1:0]   gh;
  } pte_t;

endpackage

// File: rtl/tlb_stage.sv
module tlb_stage
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pte_we,
  input  logic             asn_we,
  input  logic [63:0]      wdata,
  output pte_t             staged,
  output logic [ASN_W-1:0] cur_asn,
  output logic [63:0]      rd_pte
);

  pte_t             pte_d, pte_q;
  logic [ASN_W-1:0] asn_d, asn_q;

  // field extraction from the write value
  always_comb begin
    pte_d.ppn   = wdata[PPN_LSB +: PPN_W];
    pte_d.re    = wdata[RE_LSB +: PERM_W];
    pte_d.we    = wdata[WE_LSB +: PERM_W];
    pte_d.fo_rd = wdata[FOR_BIT];
    pte_d.fo_wr = wdata[FOW_BIT];
    pte_d.glb   = wdata[GLB_BIT];
    pte_d.gh    = wdata[GH_LSB +: GH_W];
    asn_d       = wdata[ASN_LSB +: ASN_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pte_q <= '0;
    else if (pte_we) pte_q <= pte_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      asn_q <= '0;
    else if (asn_we) asn_q <= asn_d;
  end

  // architectural repack; page number and ASN overlap at 58:57 and are ORed
  always_comb begin
    rd_pte = '0;
    rd_pte[PPN_LSB +: PPN_W] = pte_q.ppn;
    rd_pte[RE_LSB +: PERM_W] = pte_q.re;
    rd_pte[WE_LSB +: PERM_W] = pte_q.we;
    rd_pte[FOR_BIT]          = pte_q.fo_rd;
    rd_pte[FOW_BIT]          = pte_q.fo_wr;
    rd_pte[GLB_BIT]          = pte_q.glb;
    rd_pte[ASN_LSB +: ASN_W] = rd_pte[ASN_LSB +: ASN_W] | asn_q;
  end

  assign staged  = pte_q;
  assign cur_asn = asn_q;

endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);

  logic [IDX_W-1:0] ptr_d, ptr_q;

  always_comb begin
    if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_d = '0;
    else                              ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R10: each accepted insert moves the victim pointer
  p_ptr_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(adv) |-> (ptr_q != $past(ptr_q)));

endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 30,
  parameter bit IS_INSN = 1'b0,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ins,
  input  logic [IDX_W-1:0]   ins_idx,
  input  logic [VPN_W-1:0]   ins_vpn,
  input  pte_t               ins_pte,
  input  logic [ASN_W-1:0]   cur_asn,
  input  logic               inv_all,
  input  logic               inv_proc,
  input  logic               inv_one,
  input  logic [VPN_W-1:0]   inv_vpn,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output pte_t               lk_pte,
  output logic [ENTRIES-1:0] valid_vec
);

  logic [ENTRIES-1:0] valid_d, valid_q;
  logic [ENTRIES-1:0] glb_vec, hit_vec, kill_vec;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  pte_t               pte_q [ENTRIES];
  logic [ASN_W-1:0]   asn_q [ENTRIES];
  pte_t               fill_pte;

  // variant: instruction-side fills carry no write enables
  generate
    if (IS_INSN) begin : g_insn
      always_comb begin
        fill_pte    = ins_pte;
        fill_pte.we = '0;
        fill_pte.gh = '0;
      end
    end else begin : g_data
      always_comb begin
        fill_pte    = ins_pte;
        fill_pte.gh = '0;
      end
    end
  endgenerate

  // per-entry compare logic
  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic asn_ok;
      assign asn_ok      = pte_q[i].glb | (asn_q[i] == cur_asn);
      assign glb_vec[i]  = pte_q[i].glb;
      assign hit_vec[i]  = valid_q[i] & asn_ok & (vpn_q[i] == lk_vpn);
      assign kill_vec[i] = inv_all
                         | (inv_proc & ~pte_q[i].glb)
                         | (inv_one & asn_ok & (vpn_q[i] == inv_vpn));
    end
  endgenerate

  always_comb begin
    valid_d = valid_q & ~kill_vec;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ins && (ins_idx == IDX_W'(i))) valid_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // entry payload: loaded only on insert, no reset needed
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (ins && (ins_idx == IDX_W'(i))) begin
        vpn_q[i] <= ins_vpn;
        pte_q[i] <= fill_pte;
        asn_q[i] <= cur_asn;
      end
    end
  end

  // lowest-numbered matching entry wins
  always_comb begin
    lk_hit = 1'b0;
    lk_pte = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        lk_hit = 1'b1;
        lk_pte = pte_q[i];
      end
    end
  end

  assign valid_vec = valid_q;

  // R3: an accepted insert leaves its slot valid
  p_insert_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ins) |-> valid_q[$past(ins_idx)]);

  // R6: nothing survives an invalidate-all
  p_inv_all_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inv_all) |-> (valid_q == '0));

  // R7: after invalidate-process only global entries remain
  p_inv_proc_glb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inv_proc) |-> ((valid_q & ~glb_vec) == '0));

endmodule

// File: rtl/tlb_fill_ctrl.sv
module tlb_fill_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int VPN_W     = 30,
  parameter int PAGE_BITS = 13,
  parameter bit IS_INSN   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [63:0]      wr_data,
  output logic [63:0]      rd_pte,
  output logic             gh_err,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [26:0]      lk_ppn,
  output logic [3:0]       lk_rd_en,
  output logic [3:0]       lk_wr_en,
  output logic             lk_rd_fault,
  output logic             lk_wr_fault
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic               wr_pte, wr_asn, wr_tag, wr_all, wr_proc, wr_one;
  logic               tag_ok, tag_bad;
  logic               gh_d, gh_q;
  pte_t               staged, hit_pte;
  logic [ASN_W-1:0]   cur_asn;
  logic [IDX_W-1:0]   victim;
  logic [VPN_W-1:0]   wr_vpn;
  logic [ENTRIES-1:0] valid_vec;

  // command decode
  always_comb begin
    wr_pte  = wr_en & (wr_sel == SEL_PTE);
    wr_asn  = wr_en & (wr_sel == SEL_ASN);
    wr_tag  = wr_en & (wr_sel == SEL_TAG);
    wr_all  = wr_en & (wr_sel == SEL_INV_ALL);
    wr_proc = wr_en & (wr_sel == SEL_INV_PROC);
    wr_one  = wr_en & (wr_sel == SEL_INV_ONE);
    tag_bad = wr_tag & (staged.gh != '0);
    tag_ok  = wr_tag & ~tag_bad;
    gh_d    = tag_bad;
  end

  assign wr_vpn = wr_data[PAGE_BITS +: VPN_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gh_q <= 1'b0;
    else        gh_q <= gh_d;
  end

  tlb_stage u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .pte_we  (wr_pte),
    .asn_we  (wr_asn),
    .wdata   (wr_data),
    .staged  (staged),
    .cur_asn (cur_asn),
    .rd_pte  (rd_pte)
  );

  tlb_rr_ptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (tag_ok),
    .ptr   (victim)
  );

  tlb_array #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .IS_INSN (IS_INSN)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins       (tag_ok),
    .ins_idx   (victim),
    .ins_vpn   (wr_vpn),
    .ins_pte   (staged),
    .cur_asn   (cur_asn),
    .inv_all   (wr_all),
    .inv_proc  (wr_proc),
    .inv_one   (wr_one),
    .inv_vpn   (wr_vpn),
    .lk_vpn    (lk_vpn),
    .lk_hit    (lk_hit),
    .lk_pte    (hit_pte),
    .valid_vec (valid_vec)
  );

  assign gh_err      = gh_q;
  assign lk_ppn      = hit_pte.ppn;
  assign lk_rd_en    = hit_pte.re;
  assign lk_wr_en    = hit_pte.we;
  assign lk_rd_fault = hit_pte.fo_rd;
  assign lk_wr_fault = hit_pte.fo_wr;

  logic unused_hint;
  assign unused_hint = ^{hit_pte.glb, hit_pte.gh};

  // R4: a rejected tag write leaves the buffer occupancy untouched
  p_gh_no_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gh_err |-> (valid_vec == $past(valid_vec)));

  // R9: a hit needs at least one valid entry
  p_hit_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (valid_vec != '0));

endmodule

// File: tb/tlb_fill_ctrl_tb_top.sv
`timescale 1ns/1ps
module tlb_fill_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_ENT      = 8;
  localparam int VPNW       = 30;
  localparam int PGB        = 13;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [2:0]      wr_sel = '0;
  logic [63:0]     wr_data = '0;
  logic [VPNW-1:0] lk_vpn = '0;

  logic [63:0] rd_pte, rd_pte_i;
  logic        gh_err, gh_err_i;
  logic        lk_hit, lk_hit_i;
  logic [26:0] lk_ppn, lk_ppn_i;
  logic [3:0]  lk_rd_en, lk_rd_en_i, lk_wr_en, lk_wr_en_i;
  logic        lk_rd_fault, lk_wr_fault, lk_rd_fault_i, lk_wr_fault_i;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_fill_ctrl #(.ENTRIES(N_ENT), .VPN_W(VPNW), .PAGE_BITS(PGB), .IS_INSN(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_pte(rd_pte), .gh_err(gh_err), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
    .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en),
    .lk_rd_fault(lk_rd_fault), .lk_wr_fault(lk_wr_fault));

  tlb_fill_ctrl #(.ENTRIES(N_ENT), .VPN_W(VPNW), .PAGE_BITS(PGB), .IS_INSN(1'b1)) dut_insn_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_pte(rd_pte_i), .gh_err(gh_err_i), .lk_vpn(lk_vpn), .lk_hit(lk_hit_i),
    .lk_ppn(lk_ppn_i), .lk_rd_en(lk_rd_en_i), .lk_wr_en(lk_wr_en_i),
    .lk_rd_fault(lk_rd_fault_i), .lk_wr_fault(lk_wr_fault_i));

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model state
  bit          m_v   [N_ENT];
  logic [29:0] m_vpn [N_ENT];
  logic [26:0] m_ppn [N_ENT];
  logic [3:0]  m_re  [N_ENT];
  logic [3:0]  m_we  [N_ENT];
  bit          m_for [N_ENT];
  bit          m_fow [N_ENT];
  bit          m_glb [N_ENT];
  logic [6:0]  m_asn [N_ENT];
  int          m_ptr;
  logic [63:0] s_raw;
  logic [6:0]  c_asn;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_rd();
    logic [63:0] r;
    r = '0;
    r[58:32] = s_raw[58:32];
    r[15:8]  = s_raw[15:8];
    r[1]     = s_raw[1];
    r[2]     = s_raw[2];
    r[4]     = s_raw[4];
    r[63:57] = r[63:57] | c_asn;
    return r;
  endfunction

  function automatic int exp_idx(input logic [29:0] v);
    for (int i = 0; i < N_ENT; i++)
      if (m_v[i] && m_vpn[i] == v && (m_glb[i] || m_asn[i] == c_asn)) return i;
    return -1;
  endfunction

  function automatic logic [63:0] mk_pte(input logic [26:0] ppn, input logic [3:0] re,
      input logic [3:0] we, input bit fr, input bit fw, input bit g, input logic [1:0] gh);
    logic [63:0] d;
    d = {$urandom, $urandom};
    d[58:32] = ppn; d[11:8] = re; d[15:12] = we;
    d[1] = fr; d[2] = fw; d[4] = g; d[6:5] = gh;
    return d;
  endfunction

  function automatic logic [63:0] mk_addr(input logic [29:0] v);
    logic [63:0] d;
    d = {$urandom, $urandom};
    d[PGB +: VPNW] = v;
    return d;
  endfunction

  function automatic logic [63:0] mk_asn(input logic [6:0] a);
    logic [63:0] d;
    d = {$urandom, $urandom};
    d[63:57] = a;
    return d;
  endfunction

  task automatic model_apply(input logic [2:0] sel, input logic [63:0] d);
    logic [29:0] v;
    v = d[PGB +: VPNW];
    case (sel)
      3'd0: s_raw = d;
      3'd1: c_asn = d[63:57];
      3'd2: if (s_raw[6:5] == 2'b00) begin
        m_v[m_ptr] = 1'b1; m_vpn[m_ptr] = v; m_ppn[m_ptr] = s_raw[58:32];
        m_re[m_ptr] = s_raw[11:8]; m_we[m_ptr] = s_raw[15:12];
        m_for[m_ptr] = s_raw[1]; m_fow[m_ptr] = s_raw[2]; m_glb[m_ptr] = s_raw[4];
        m_asn[m_ptr] = c_asn;
        m_ptr = (m_ptr + 1) % N_ENT;
      end
      3'd3: for (int i = 0; i < N_ENT; i++) m_v[i] = 1'b0;
      3'd4: for (int i = 0; i < N_ENT; i++) if (!m_glb[i]) m_v[i] = 1'b0;
      3'd5: for (int i = 0; i < N_ENT; i++)
              if (m_vpn[i] == v && (m_glb[i] || m_asn[i] == c_asn)) m_v[i] = 1'b0;
      default: ;
    endcase
  endtask

  // one write, then checks of gh_err and rd_pte at the following low phase
  task automatic do_wr(input logic [2:0] sel, input logic [63:0] d, input string req);
    bit exp_gh;
    exp_gh = (sel == 3'd2) && (s_raw[6:5] != 2'b00);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = '0;
    model_apply(sel, d);
    chk(gh_err == exp_gh, {req, " R4 gh_err"}, 64'(gh_err), 64'(exp_gh));
    chk(gh_err_i == exp_gh, {req, " R4 gh_err insn"}, 64'(gh_err_i), 64'(exp_gh));
    chk(rd_pte == exp_rd(), {req, " R5 rd_pte"}, rd_pte, exp_rd());
  endtask

  task automatic look(input logic [29:0] v, input string req);
    int k;
    logic [63:0] ev, av;
    k = exp_idx(v);
    lk_vpn = v;
    #0.5;
    chk(lk_hit == (k >= 0), {req, " R9 hit"}, 64'(lk_hit), 64'(k >= 0));
    chk(lk_hit_i == (k >= 0), {req, " R11 hit insn"}, 64'(lk_hit_i), 64'(k >= 0));
    chk(lk_wr_en_i == 4'h0, {req, " R11 insn write enables"}, 64'(lk_wr_en_i), 64'h0);
    av = {lk_ppn, lk_rd_en, lk_wr_en, lk_rd_fault, lk_wr_fault};
    ev = (k >= 0) ? {m_ppn[k], m_re[k], m_we[k], m_for[k], m_fow[k]} : 64'h0;
    chk(av == ev, {req, " R9 lookup data"}, av, ev);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < N_ENT; i++) begin
      m_v[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0; m_re[i] = '0; m_we[i] = '0;
      m_for[i] = 0; m_fow[i] = 0; m_glb[i] = 0; m_asn[i] = '0;
    end
    m_ptr = 0; s_raw = '0; c_asn = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rd_pte == 64'h0, "R1 rd_pte", rd_pte, 64'h0);
    chk(gh_err == 1'b0, "R1 gh_err", 64'(gh_err), 64'h0);
    look(30'd0, "R1 reset");
    look(30'd5, "R1 reset");

    // R2 staging alone inserts nothing
    do_wr(3'd0, mk_pte(27'h5a5a5a5, 4'hf, 4'h3, 1, 0, 0, 2'b00), "R2 stage");
    look(30'd0, "R2 no insert");
    do_wr(3'd1, mk_asn(7'd3), "R2 asn");
    // R3 insert, R9 asn mismatch / match
    do_wr(3'd2, mk_addr(30'd7), "R3 tag");
    look(30'd7, "R3 hit");
    do_wr(3'd1, mk_asn(7'd4), "R9 asn change");
    look(30'd7, "R9 asn mismatch miss");
    // global entry hits under any asn
    do_wr(3'd0, mk_pte(27'h0000123, 4'h1, 4'h2, 0, 1, 1, 2'b00), "R9 stage glb");
    do_wr(3'd2, mk_addr(30'd9), "R9 tag glb");
    do_wr(3'd1, mk_asn(7'd1), "R9 asn");
    look(30'd9, "R9 global hit");
    // R4 nonzero hint rejected
    do_wr(3'd0, mk_pte(27'h7ffffff, 4'h2, 4'h2, 1, 1, 1, 2'b10), "R4 stage gh");
    do_wr(3'd2, mk_addr(30'd11), "R4 tag gh");
    look(30'd11, "R4 no insert");
    // R12 ignored selects
    do_wr(3'd6, mk_pte(27'h1, 4'h1, 4'h1, 0, 0, 0, 2'b00), "R12 sel6");
    do_wr(3'd7, mk_addr(30'd9), "R12 sel7");
    look(30'd9, "R12 kept");
    // R10 wraparound: ten inserts, first overwritten
    do_wr(3'd3, 64'h0, "R6 clear");
    look(30'd9, "R6 cleared");
    for (int i = 0; i < 10; i++) begin
      do_wr(3'd0, mk_pte(27'(i + 100), 4'(i), 4'(i + 1), 0, 0, i[0], 2'b00), "R10 stage");
      do_wr(3'd2, mk_addr(30'(i + 20)), "R10 fill");
    end
    look(30'd20, "R10 overwritten");
    look(30'd21, "R10 overwritten");
    look(30'd22, "R10 kept");
    look(30'd29, "R10 newest");
    // R7 process invalidate
    do_wr(3'd4, 64'h0, "R7 inv proc");
    look(30'd23, "R7 glb kept");
    look(30'd24, "R7 private gone");
    // R8 single invalidate
    do_wr(3'd5, mk_addr(30'd23), "R8 inv one");
    look(30'd23, "R8 removed");
    look(30'd25, "R8 neighbour kept");

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 25)      d = mk_pte(27'($urandom), 4'($urandom), 4'($urandom), $urandom_range(0,1),
                              $urandom_range(0,1), $urandom_range(0,1),
                              ($urandom_range(0,7) == 0) ? 2'($urandom_range(1,3)) : 2'b00);
      else if (r < 35) d = mk_asn(7'($urandom_range(0,3)));
      else if (r < 75) d = mk_addr(30'($urandom_range(0,15)));
      else if (r < 95) d = mk_addr(30'($urandom_range(0,15)));
      else             d = {$urandom, $urandom};
      if (r < 25)      do_wr(3'd0, d, "R2 rnd stage");
      else if (r < 35) do_wr(3'd1, d, "R2 rnd asn");
      else if (r < 75) do_wr(3'd2, d, "R3 rnd tag");
      else if (r < 85) do_wr(3'd5, d, "R8 rnd inv one");
      else if (r < 90) do_wr(3'd4, d, "R7 rnd inv proc");
      else if (r < 93) do_wr(3'd3, d, "R6 rnd inv all");
      else             do_wr(3'($urandom_range(6,7)), d, "R12 rnd ignored");
      for (int j = 0; j < 4; j++) look(30'($urandom_range(0,15)), "R9 rnd");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule